// File: doc/BRIEF.md
# PHY Register Access Controller

This block lets software reach the registers inside an attached physical-layer device one at a time. The host writes a 32-bit command word that carries a read-request bit, a write-request bit, a 4-bit PHY register address and 8 bits of data to write. The controller turns that word into a single request on a valid/ready port towards the PHY side. When the request is accepted, the matching request bit clears itself. For a read, the controller then waits on a response port. The returned byte and the address it came from are stored in read-only fields of the same command word, and a sticky received-data status bit is raised. That bit can drive an interrupt when its enable is set.

Whenever bus self-identification completes, the controller queues an automatic read of PHY register 0. The queued read is issued as soon as the controller is idle, so any host command already in flight finishes first. Only one access can be outstanding. A host command that arrives while an access is in progress is discarded, and a sticky error flag records the loss.

The core is a three-state machine. `ST_IDLE` waits for work. The transition *launch* (a host request, or the queued automatic read) moves it to `ST_SEND`, where `req_valid` is high. From `ST_SEND`, the transition *write accepted* returns to `ST_IDLE`, and *read accepted* moves on to `ST_WAIT`. In `ST_WAIT`, the transition *response* returns to `ST_IDLE` and captures the data.

Top module: `phy_reg_access`

## Requirements
- R1: After reset, `host_rdata` reads 0x00000000, and `req_valid`, `rx_stat` and `irq` are all 0.
- R2: In idle, a host write with bit 31 set issues a read request. `req_valid` rises with `req_is_write`=0 and `req_addr` taken from bits 27..24. Bit 31 reads back as 1 until the request is accepted (`req_valid` and `req_ready` both high) and reads 0 from then on.
- R3: In idle, a host write with bit 30 set and bit 31 clear issues a write request. `req_is_write`=1, `req_addr` comes from bits 27..24 and `req_data` from bits 23..16. Bit 30 reads back as 1 until acceptance and 0 afterwards. Bits 27..24 and 23..16 read back the values written.
- R4: A response that arrives while a read is awaited is stored: its address in bits 11..8 and its data in bits 7..0. A response that arrives at any other time changes nothing.
- R5: A stored response sets `rx_stat`. The bit stays set until a `rx_stat_clr` pulse clears it. `irq` equals `rx_stat` AND `rx_irq_en`.
- R6: If bits 31 and 30 are both set in one write, a read is issued and the write bit is ignored.
- R7: A host write with bit 31 or 30 set that arrives while an access is in progress is dropped. No request is issued for it, the address and data fields are left unchanged, and the sticky error bit 29 is set. In idle, a host write with bit 29 set clears the error bit.
- R8: A `selfid_done` pulse queues a read of PHY register 0. The read is launched the first cycle the controller is idle, after any pending host access has completed. Bit 31 reads back as 1 while it is being sent.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_is_write`, `req_addr` and `req_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Command word read back: request bits, error, fields, received address and data |
| rx_stat_clr | input | 1 | Pulse that clears the received-data status |
| rx_irq_en | input | 1 | Interrupt enable for the received-data status |
| rx_stat | output | 1 | Sticky received-data status |
| irq | output | 1 | Interrupt request |
| selfid_done | input | 1 | Pulse marking the end of self-identification |
| req_valid | output | 1 | PHY request valid |
| req_ready | input | 1 | PHY side accepts the request |
| req_is_write | output | 1 | 1 for a register write, 0 for a read |
| req_addr | output | 4 | PHY register address |
| req_data | output | 8 | Data to write |
| rsp_valid | input | 1 | PHY read response valid |
| rsp_addr | input | 4 | Address the response came from |
| rsp_data | input | 8 | Read data |

## Verification
The bench builds the block with its default 4-bit address and 8-bit data fields. That size is small enough to sweep all sixteen PHY register addresses through both a write and a read. Each address uses its own data pattern computed arithmetically, along with a varying accept delay and a varying response delay. This brings every address field value, hold-while-stalled behaviour and the interrupt gate in both enable states within reach. Targeted sequences cover the remaining cases: a command that sets both request bits, a command issued while an access is busy, a stray response, and self-ID reads that arrive while idle and while a host access is stalled.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
    localparam int CMD_W     = 32;
    localparam int PA_W      = 4;
    localparam int PD_W      = 8;
    localparam int RD_BIT    = 31;
    localparam int WR_BIT    = 30;
    localparam int ERR_BIT   = 29;
    localparam int TADDR_LSB = 24;
    localparam int TDATA_LSB = 16;
    localparam int RADDR_LSB = 8;
    localparam int RDATA_LSB = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } acc_state_t;
endpackage

// File: rtl/phy_acc_fsm.sv
module phy_acc_fsm
    import phy_acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_go,
    input  logic            host_is_wr,
    input  logic [PA_W-1:0] host_addr,
    input  logic [PD_W-1:0] host_data,
    input  logic            selfid_done,
    input  logic            req_ready,
    input  logic            rsp_valid,
    output acc_state_t      state,
    output logic            req_valid,
    output logic            req_is_write,
    output logic [PA_W-1:0] req_addr,
    output logic [PD_W-1:0] req_data,
    output logic            rsp_take
);
    acc_state_t      state_q, state_d;
    logic            auto_pend_q;
    logic            auto_take;
    logic            load_host;
    logic            cur_wr_q;
    logic [PA_W-1:0] cur_addr_q;
    logic [PD_W-1:0] cur_data_q;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        load_host = 1'b0;
        auto_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_go) begin
                    load_host = 1'b1;
                    state_d   = ST_SEND;
                end else if (auto_pend_q) begin
                    auto_take = 1'b1;
                    state_d   = ST_SEND;
                end
            end
            ST_SEND: if (req_ready) state_d = cur_wr_q ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured request and queued automatic read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr_q    <= 1'b0;
            cur_addr_q  <= '0;
            cur_data_q  <= '0;
            auto_pend_q <= 1'b0;
        end else begin
            if (load_host) begin
                cur_wr_q   <= host_is_wr;
                cur_addr_q <= host_addr;
                cur_data_q <= host_data;
            end else if (auto_take) begin
                cur_wr_q   <= 1'b0;
                cur_addr_q <= '0;
                cur_data_q <= '0;
            end
            if (selfid_done)    auto_pend_q <= 1'b1;
            else if (auto_take) auto_pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        state        = state_q;
        req_valid    = (state_q == ST_SEND);
        req_is_write = cur_wr_q;
        req_addr     = cur_addr_q;
        req_data     = cur_data_q;
        rsp_take     = (state_q == ST_WAIT) && rsp_valid;
    end

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_is_write) && $stable(req_data));
    p_auto_reg0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_take |=> req_valid && (req_addr == '0) && !req_is_write);
    p_drop_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid);
endmodule

// File: rtl/phy_acc_regs.sv
module phy_acc_regs
    import phy_acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [CMD_W-1:0] host_wdata,
    input  acc_state_t       state,
    input  logic             req_is_write,
    input  logic             rsp_take,
    input  logic [PA_W-1:0]  rsp_addr,
    input  logic [PD_W-1:0]  rsp_data,
    output logic [CMD_W-1:0] host_rdata,
    output logic             host_go,
    output logic             host_is_wr,
    output logic [PA_W-1:0]  host_addr,
    output logic [PD_W-1:0]  host_data
);
    logic            idle, has_cmd, drop;
    logic [PA_W-1:0] taddr_q, raddr_q;
    logic [PD_W-1:0] tdata_q, rdata_q;
    logic            err_q;
    logic            unused_bits;

    assign idle       = (state == ST_IDLE);
    assign has_cmd    = host_wdata[RD_BIT] | host_wdata[WR_BIT];
    assign host_go    = host_wr && idle && has_cmd;
    assign drop       = host_wr && !idle && has_cmd;
    assign host_is_wr = !host_wdata[RD_BIT];
    assign host_addr  = host_wdata[TADDR_LSB +: PA_W];
    assign host_data  = host_wdata[TDATA_LSB +: PD_W];
    assign unused_bits = ^{host_wdata[28], host_wdata[15:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taddr_q <= '0;
            tdata_q <= '0;
            raddr_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (host_wr && idle) begin
                taddr_q <= host_addr;
                tdata_q <= host_data;
            end
            if (drop)
                err_q <= 1'b1;
            else if (host_wr && idle && host_wdata[ERR_BIT])
                err_q <= 1'b0;
            if (rsp_take) begin
                raddr_q <= rsp_addr;
                rdata_q <= rsp_data;
            end
        end
    end

    always_comb begin
        host_rdata                         = '0;
        host_rdata[RD_BIT]                 = (state == ST_SEND) && !req_is_write;
        host_rdata[WR_BIT]                 = (state == ST_SEND) && req_is_write;
        host_rdata[ERR_BIT]                = err_q;
        host_rdata[TADDR_LSB +: PA_W]      = taddr_q;
        host_rdata[TDATA_LSB +: PD_W]      = tdata_q;
        host_rdata[RADDR_LSB +: PA_W]      = raddr_q;
        host_rdata[RDATA_LSB +: PD_W]      = rdata_q;
    end

    p_drop_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> host_rdata[ERR_BIT]);
    p_drop_keeps_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(host_rdata[TADDR_LSB +: PA_W]));
endmodule

// File: rtl/phy_acc_irq.sv
module phy_acc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rsp_take,
    input  logic stat_clr,
    input  logic irq_en,
    output logic rx_stat,
    output logic irq
);
    logic stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (rsp_take) stat_q <= 1'b1;
        else if (stat_clr) stat_q <= 1'b0;
    end

    assign rx_stat = stat_q;
    assign irq     = stat_q & irq_en;

    p_stat_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> rx_stat);
    p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stat && !stat_clr |=> rx_stat);
endmodule

// File: rtl/phy_reg_access.sv
module phy_reg_access
    import phy_acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        rx_stat_clr,
    input  logic        rx_irq_en,
    output logic        rx_stat,
    output logic        irq,
    input  logic        selfid_done,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_is_write,
    output logic [3:0]  req_addr,
    output logic [7:0]  req_data,
    input  logic        rsp_valid,
    input  logic [3:0]  rsp_addr,
    input  logic [7:0]  rsp_data
);
    acc_state_t      state;
    logic            host_go, host_is_wr, rsp_take;
    logic [PA_W-1:0] host_addr;
    logic [PD_W-1:0] host_data;

    phy_acc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .state(state), .req_is_write(req_is_write), .rsp_take(rsp_take),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data), .host_rdata(host_rdata),
        .host_go(host_go), .host_is_wr(host_is_wr), .host_addr(host_addr),
        .host_data(host_data)
    );

    phy_acc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .host_go(host_go), .host_is_wr(host_is_wr),
        .host_addr(host_addr), .host_data(host_data), .selfid_done(selfid_done),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .state(state),
        .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
        .req_data(req_data), .rsp_take(rsp_take)
    );

    phy_acc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .rsp_take(rsp_take), .stat_clr(rx_stat_clr),
        .irq_en(rx_irq_en), .rx_stat(rx_stat), .irq(irq)
    );

    p_read_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !req_valid && (state == ST_IDLE) && host_wdata[31] && host_wdata[30]
        |=> req_valid && !req_is_write);
endmodule

// File: tb/tb_phy_reg_access.sv
module tb_phy_reg_access;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rx_stat_clr = 1'b0;
    logic        rx_irq_en = 1'b0;
    logic        rx_stat, irq;
    logic        selfid_done = 1'b0;
    logic        req_valid, req_is_write;
    logic        req_ready = 1'b0;
    logic [3:0]  req_addr;
    logic [7:0]  req_data;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_addr = '0;
    logic [7:0]  rsp_data = '0;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    phy_reg_access dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_stat_clr(rx_stat_clr), .rx_irq_en(rx_irq_en),
        .rx_stat(rx_stat), .irq(irq), .selfid_done(selfid_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
        .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic rd, input logic wr, input logic er,
                                       input logic [3:0] a, input logic [7:0] d);
        return {rd, wr, er, 1'b0, a, d, 16'h0000};
    endfunction

    function automatic logic [7:0] rsp_of(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    task automatic host_cmd(input logic [31:0] w);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic shake();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic respond(input logic [3:0] a, input logic [7:0] d);
        rsp_valid = 1'b1; rsp_addr = a; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic clr_stat();
        rx_stat_clr = 1'b1;
        @(negedge clk);
        rx_stat_clr = 1'b0;
    endtask

    task automatic pulse_selfid();
        selfid_done = 1'b1;
        @(negedge clk);
        selfid_done = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 req_valid", {31'b0, req_valid}, 32'h0);
        chk("R1 rx_stat", {31'b0, rx_stat}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 / R9: write sweep over all addresses
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 11) & 255);
            host_cmd(mk(1'b0, 1'b1, 1'b0, 4'(a), d));
            chk("R3 valid", {31'b0, req_valid}, 32'h1);
            chk("R3 is_write", {31'b0, req_is_write}, 32'h1);
            chk("R3 addr", {28'b0, req_addr}, 32'(a));
            chk("R3 data", {24'b0, req_data}, {24'b0, d});
            chk("R3 bit30 set", {31'b0, host_rdata[30]}, 32'h1);
            for (int w = 0; w < a % 3; w++) begin
                @(negedge clk);
                chk("R9 held valid", {31'b0, req_valid}, 32'h1);
                chk("R9 held addr", {28'b0, req_addr}, 32'(a));
                chk("R9 held data", {24'b0, req_data}, {24'b0, d});
            end
            shake();
            chk("R3 valid dropped", {31'b0, req_valid}, 32'h0);
            chk("R3 bit30 clear", {31'b0, host_rdata[30]}, 32'h0);
            chk("R3 field readback", {16'b0, host_rdata[31:16]}, {16'b0, 4'h0, 4'(a), d});
        end

        // R2 / R4 / R5: read sweep
        for (int a = 0; a < 16; a++) begin
            rx_irq_en = a[0];
            host_cmd(mk(1'b1, 1'b0, 1'b0, 4'(a), 8'h00));
            chk("R2 valid", {31'b0, req_valid}, 32'h1);
            chk("R2 is_write", {31'b0, req_is_write}, 32'h0);
            chk("R2 addr", {28'b0, req_addr}, 32'(a));
            chk("R2 bit31 set", {31'b0, host_rdata[31]}, 32'h1);
            shake();
            chk("R2 bit31 clear", {31'b0, host_rdata[31]}, 32'h0);
            chk("R2 valid dropped", {31'b0, req_valid}, 32'h0);
            repeat (a % 2) @(negedge clk);
            respond(4'(a), rsp_of(a));
            chk("R4 rx addr", {28'b0, host_rdata[11:8]}, 32'(a));
            chk("R4 rx data", {24'b0, host_rdata[7:0]}, {24'b0, rsp_of(a)});
            chk("R5 stat set", {31'b0, rx_stat}, 32'h1);
            chk("R5 irq gate", {31'b0, irq}, 32'(a % 2));
            @(negedge clk);
            chk("R5 stat sticky", {31'b0, rx_stat}, 32'h1);
            clr_stat();
            chk("R5 stat cleared", {31'b0, rx_stat}, 32'h0);
            chk("R5 irq cleared", {31'b0, irq}, 32'h0);
        end

        // R4: stray response in idle is ignored
        respond(4'h3, 8'hEE);
        chk("R4 stray ignored", {20'b0, host_rdata[11:0]}, {20'b0, 4'hF, rsp_of(15)});
        chk("R4 stray no stat", {31'b0, rx_stat}, 32'h0);

        // R6: both request bits -> read
        host_cmd(mk(1'b1, 1'b1, 1'b0, 4'h5, 8'hAA));
        chk("R6 read chosen", {31'b0, req_is_write}, 32'h0);
        chk("R6 addr", {28'b0, req_addr}, 32'h5);
        chk("R6 bit30 clear", {31'b0, host_rdata[30]}, 32'h0);
        shake();

        // R7: command while busy is dropped
        host_cmd(mk(1'b0, 1'b1, 1'b0, 4'h9, 8'h33));
        chk("R7 err set", {31'b0, host_rdata[29]}, 32'h1);
        chk("R7 no request", {31'b0, req_valid}, 32'h0);
        chk("R7 field kept", {28'b0, host_rdata[27:24]}, 32'h5);
        respond(4'h5, rsp_of(5));
        chk("R7 no late launch", {31'b0, req_valid}, 32'h0);
        @(negedge clk);
        chk("R7 still idle", {31'b0, req_valid}, 32'h0);
        chk("R7 err sticky", {31'b0, host_rdata[29]}, 32'h1);
        clr_stat();
        host_cmd(mk(1'b0, 1'b0, 1'b1, 4'h0, 8'h00));
        chk("R7 err cleared", {31'b0, host_rdata[29]}, 32'h0);
        chk("R7 clear issues nothing", {31'b0, req_valid}, 32'h0);

        // R8: self-ID while idle
        pulse_selfid();
        @(negedge clk);
        chk("R8 auto valid", {31'b0, req_valid}, 32'h1);
        chk("R8 auto addr", {28'b0, req_addr}, 32'h0);
        chk("R8 auto read", {31'b0, req_is_write}, 32'h0);
        chk("R8 bit31 set", {31'b0, host_rdata[31]}, 32'h1);
        shake();
        respond(4'h0, 8'h5C);
        chk("R8 auto capture", {20'b0, host_rdata[11:0]}, {20'b0, 12'h05C});
        chk("R8 auto stat", {31'b0, rx_stat}, 32'h1);
        clr_stat();

        // R8: self-ID during a stalled host write
        host_cmd(mk(1'b0, 1'b1, 1'b0, 4'h7, 8'h12));
        pulse_selfid();
        @(negedge clk);
        chk("R8 host first addr", {28'b0, req_addr}, 32'h7);
        chk("R8 host first write", {31'b0, req_is_write}, 32'h1);
        shake();
        chk("R8 gap after host", {31'b0, req_valid}, 32'h0);
        @(negedge clk);
        chk("R8 queued valid", {31'b0, req_valid}, 32'h1);
        chk("R8 queued addr", {28'b0, req_addr}, 32'h0);
        chk("R8 queued read", {31'b0, req_is_write}, 32'h0);
        shake();
        respond(4'h0, 8'h21);
        chk("R8 queued capture", {20'b0, host_rdata[11:0]}, {20'b0, 12'h021});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule